// File: doc/BRIEF.md
# Command-List Entry Fetcher

The fetcher accepts 64-bit command-list entries, each describing a segment of 32-bit command words held in memory, together with the number of the channel that owns the segment. Every entry is decoded into a 40-bit byte start address and a length in words and then held in a small in-order queue. A read engine takes entries from the head of the queue, issues one read per word over a simple request/response memory port, and forwards the returned words to a downstream command decoder with valid/ready handshaking. A last-word flag marks the end of each segment.

Reads may run ahead of the downstream consumer, which is prefetching, until a segment marked for wait is met. A wait-marked entry, and every entry after it in the same pushed batch, only starts its reads once all words already requested have been taken by the consumer. A one-cycle pulse tells the consumer that the owning channel has changed, so it can refresh its state before the new segment's words arrive. An interrupt input lets the current segment finish and then pauses dispatch for one loop turn, which is reported by a pulse.

Top module: `cmdlist_fetcher`

## Requirements
- R1: The start address is `{ent_hi[7:0], ent_lo[31:2], 2'b00}`; bits 1:0 of `ent_lo` and bits 9:8 of `ent_hi` are ignored.
- R2: A segment whose length field `ent_hi[30:10]` is N issues exactly N read requests, the first at the start address and each later one 4 higher, carried across all 40 address bits.
- R3: An entry with a length of zero issues no read and produces no word, and the next entry is taken right after it.
- R4: The entry queue holds `Q_DEPTH` entries; when it is full `q_full` is 1, `ent_ready` is 0 and an offered entry is not taken.
- R5: An entry with `ent_hi[31]` = 1 (wait) issues its first read only after every word requested before it has been accepted downstream.
- R6: An entry pushed after a wait entry with `ent_first` = 0 is treated as a wait entry too; `ent_first` = 1 starts a new batch in which only its own wait bit counts.
- R7: An entry with no wait in effect may issue its reads while words of earlier segments are still waiting for the consumer.
- R8: `chan_chg` pulses for one cycle when an entry is taken whose `ent_chan` differs from that of the previous taken entry, and for the first entry after reset; it stays 0 when the channel repeats.
- R9: After `intr` is seen, no further entry is taken until the segment in progress has issued all its reads; then `stop_done` pulses once and dispatch resumes.
- R10: Words leave in request order with the data returned by memory, and `word_last` is 1 on exactly the final word of each segment.
- R11: After reset `ent_ready` is 1, `q_empty` is 1 and `word_valid`, `rd_req_valid`, `chan_chg` and `stop_done` are 0.
- R12: No more than `RB_DEPTH` words are ever requested but not yet accepted downstream, so the response store never overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_valid | input | 1 | Entry offered |
| ent_ready | output | 1 | Entry queue has room |
| ent_lo | input | 32 | Low word of the entry |
| ent_hi | input | 32 | High word of the entry |
| ent_chan | input | CH_W | Channel owning the entry |
| ent_first | input | 1 | Entry opens a new batch |
| intr | input | 1 | Stop request |
| stop_done | output | 1 | Pulse: dispatch paused after a stop request |
| chan_chg | output | 1 | Pulse: owning channel changed |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | 40 | Byte address of the word to read |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | 32 | Returned word |
| word_valid | output | 1 | Command word available |
| word_ready | input | 1 | Consumer takes the word |
| word_data | output | 32 | Command word |
| word_last | output | 1 | Final word of its segment |
| q_full | output | 1 | Entry queue full |
| q_empty | output | 1 | Entry queue empty |

## Verification
The assertions assume that memory answers only requests it has accepted, in order, one word per cycle, and with no way to stall a response; the bench's memory model keeps a list of accepted addresses and returns them one cycle later or more in that order. They also assume the consumer never takes a word that is not offered, which the bench guarantees by sampling `word_valid` before counting a transfer. Stimulus holds the request and consumer ready lines high, toggles them in fixed patterns, or holds them low so that prefetch, deferral, queue-full and stop behaviour are all visible at the ports.

// File: rtl/cmdf_pkg.sv
package cmdf_pkg;

   localparam int ADDR_W = 40;
   localparam int LEN_W  = 21;

   typedef struct packed {
      logic              wait_req;
      logic [LEN_W-1:0]  len;
      logic [ADDR_W-1:0] addr;
   } seg_desc_t;

   function automatic seg_desc_t unpack_entry(input logic [31:0] lo, input logic [31:0] hi);
      seg_desc_t d;
      d.addr     = {hi[7:0], lo[31:2], 2'b00};
      d.len      = hi[30:10];
      d.wait_req = hi[31];
      return d;
   endfunction

endpackage

// File: rtl/cmdf_fifo.sv
module cmdf_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic             full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("cmdf_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] store [DEPTH];
   logic [PW-1:0]    wp_q, rp_q, wp_nx, rp_nx;
   logic [CW-1:0]    cnt_q;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_nx = wp_q + 1'b1;
         assign rp_nx = rp_q + 1'b1;
      end else begin : g_wrap
         assign wp_nx = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
         assign rp_nx = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) store[wp_q] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wp_q <= wp_nx;
         if (pop)  rp_q <= rp_nx;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign rdata = store[rp_q];
   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CW'(DEPTH));

   // R12: nothing is written into a full store
   p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R10: nothing is read from an empty store
   p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/cmdf_entry_dec.sv
module cmdf_entry_dec
   import cmdf_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [31:0]      lo,
   input  logic [31:0]      hi,
   input  logic             first,
   input  logic             accept,
   output logic [ADDR_W-1:0] addr,
   output logic [LEN_W-1:0]  len,
   output logic             deferred
);
   seg_desc_t desc;
   logic      batch_wait_q;
   logic      prior_wait;

   always_comb begin
      desc       = unpack_entry(lo, hi);
      prior_wait = first ? 1'b0 : batch_wait_q;
      deferred   = prior_wait | desc.wait_req;
      addr       = desc.addr;
      len        = desc.len;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      batch_wait_q <= 1'b0;
      else if (accept) batch_wait_q <= deferred;
   end

   // R6: a batch that has seen a wait keeps deferring until a new batch opens
   p_batch_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && deferred) |=> (accept && !first) |-> deferred);

endmodule

// File: rtl/cmdf_seg_reader.sv
module cmdf_seg_reader
   import cmdf_pkg::*;
#(
   parameter int CH_W     = 3,
   parameter int RB_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              head_valid,
   input  logic [ADDR_W-1:0] head_addr,
   input  logic [LEN_W-1:0]  head_len,
   input  logic              head_deferred,
   input  logic [CH_W-1:0]   head_chan,
   output logic              head_pop,
   input  logic              intr,
   output logic              stop_done,
   output logic              chan_chg,
   output logic              rd_req_valid,
   input  logic              rd_req_ready,
   output logic [ADDR_W-1:0] rd_req_addr,
   output logic              tag_push,
   output logic              tag_last,
   input  logic              word_fire
);
   localparam int IW = $clog2(RB_DEPTH + 1);

   logic              active_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  left_q;
   logic [CH_W-1:0]   prev_chan_q;
   logic              have_prev_q;
   logic [IW-1:0]     inflight_q;
   logic              stop_pend_q;
   logic              drained, credit_ok, rd_fire;

   assign drained   = (inflight_q == '0);
   assign credit_ok = (inflight_q < IW'(RB_DEPTH));
   assign head_pop  = head_valid && !active_q && !stop_pend_q && !intr &&
                      (!head_deferred || drained);

   assign rd_req_valid = active_q && credit_ok;
   assign rd_req_addr  = addr_q;
   assign rd_fire      = rd_req_valid && rd_req_ready;
   assign tag_push     = rd_fire;
   assign tag_last     = (left_q == LEN_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q    <= 1'b0;
         addr_q      <= '0;
         left_q      <= '0;
         prev_chan_q <= '0;
         have_prev_q <= 1'b0;
         chan_chg    <= 1'b0;
      end else begin
         chan_chg <= 1'b0;
         if (head_pop) begin
            active_q    <= (head_len != '0);
            addr_q      <= head_addr;
            left_q      <= head_len;
            prev_chan_q <= head_chan;
            have_prev_q <= 1'b1;
            chan_chg    <= !have_prev_q || (head_chan != prev_chan_q);
         end else if (rd_fire) begin
            addr_q <= addr_q + ADDR_W'(4);
            left_q <= left_q - 1'b1;
            if (left_q == LEN_W'(1)) active_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inflight_q <= '0;
      end else begin
         case ({rd_fire, word_fire})
            2'b10:   inflight_q <= inflight_q + 1'b1;
            2'b01:   inflight_q <= inflight_q - 1'b1;
            default: inflight_q <= inflight_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stop_pend_q <= 1'b0;
         stop_done   <= 1'b0;
      end else begin
         stop_done <= 1'b0;
         if (stop_pend_q && !active_q) begin
            stop_pend_q <= 1'b0;
            stop_done   <= 1'b1;
         end
         if (intr) stop_pend_q <= 1'b1;
      end
   end

   // R2: consecutive reads of one segment step by one word
   p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fire && left_q > LEN_W'(1)) |=> (rd_req_addr == $past(rd_req_addr) + ADDR_W'(4)));
   // R8: a channel pulse only follows a taken entry
   p_chg_after_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
      chan_chg |-> $past(head_pop));
   // R9: nothing is taken while a stop is pending
   p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pend_q |-> !head_pop);
   // R9: the pause pulse lasts one cycle
   p_stop_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_done && !$past(intr)) |=> !stop_done);
   // R5: a deferred segment starts with nothing outstanding
   p_defer_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (head_pop && head_deferred) |=> (inflight_q == '0));

endmodule

// File: rtl/cmdlist_fetcher.sv
module cmdlist_fetcher
   import cmdf_pkg::*;
#(
   parameter int Q_DEPTH  = 4,
   parameter int RB_DEPTH = 8,
   parameter int CH_W     = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ent_valid,
   output logic            ent_ready,
   input  logic [31:0]     ent_lo,
   input  logic [31:0]     ent_hi,
   input  logic [CH_W-1:0] ent_chan,
   input  logic            ent_first,
   input  logic            intr,
   output logic            stop_done,
   output logic            chan_chg,
   output logic            rd_req_valid,
   input  logic            rd_req_ready,
   output logic [39:0]     rd_req_addr,
   input  logic            rd_rsp_valid,
   input  logic [31:0]     rd_rsp_data,
   output logic            word_valid,
   input  logic            word_ready,
   output logic [31:0]     word_data,
   output logic            word_last,
   output logic            q_full,
   output logic            q_empty
);
   localparam int QW = CH_W + 1 + LEN_W + ADDR_W;

   generate
      if (Q_DEPTH < 2 || RB_DEPTH < 2) begin : g_bad_depth
         $error("cmdlist_fetcher: queue and response depths must be at least 2");
      end
      if (CH_W < 1) begin : g_bad_chan
         $error("cmdlist_fetcher: CH_W must be at least 1");
      end
   endgenerate

   logic              accept;
   logic [ADDR_W-1:0] dec_addr;
   logic [LEN_W-1:0]  dec_len;
   logic              dec_deferred;
   logic [QW-1:0]     q_wdata, q_rdata;
   logic              q_pop;
   logic              tag_push, tag_last_in, tag_empty, tag_full;
   logic              rsp_empty, rsp_full, word_fire;

   assign ent_ready = !q_full;
   assign accept    = ent_valid && ent_ready;

   cmdf_entry_dec u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .lo       (ent_lo),
      .hi       (ent_hi),
      .first    (ent_first),
      .accept   (accept),
      .addr     (dec_addr),
      .len      (dec_len),
      .deferred (dec_deferred)
   );

   assign q_wdata = {ent_chan, dec_deferred, dec_len, dec_addr};

   cmdf_fifo #(.WIDTH(QW), .DEPTH(Q_DEPTH)) u_entq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (accept),
      .wdata (q_wdata),
      .pop   (q_pop),
      .rdata (q_rdata),
      .empty (q_empty),
      .full  (q_full)
   );

   cmdf_seg_reader #(.CH_W(CH_W), .RB_DEPTH(RB_DEPTH)) u_rd (
      .clk           (clk),
      .rst_n         (rst_n),
      .head_valid    (!q_empty),
      .head_addr     (q_rdata[ADDR_W-1:0]),
      .head_len      (q_rdata[ADDR_W +: LEN_W]),
      .head_deferred (q_rdata[ADDR_W+LEN_W]),
      .head_chan     (q_rdata[QW-1 -: CH_W]),
      .head_pop      (q_pop),
      .intr          (intr),
      .stop_done     (stop_done),
      .chan_chg      (chan_chg),
      .rd_req_valid  (rd_req_valid),
      .rd_req_ready  (rd_req_ready),
      .rd_req_addr   (rd_req_addr),
      .tag_push      (tag_push),
      .tag_last      (tag_last_in),
      .word_fire     (word_fire)
   );

   assign word_valid = !rsp_empty;
   assign word_fire  = word_valid && word_ready;

   cmdf_fifo #(.WIDTH(1), .DEPTH(RB_DEPTH)) u_tagq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (tag_push),
      .wdata (tag_last_in),
      .pop   (word_fire),
      .rdata (word_last),
      .empty (tag_empty),
      .full  (tag_full)
   );

   cmdf_fifo #(.WIDTH(32), .DEPTH(RB_DEPTH)) u_rspq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rd_rsp_valid),
      .wdata (rd_rsp_data),
      .pop   (word_fire),
      .rdata (word_data),
      .empty (rsp_empty),
      .full  (rsp_full)
   );

   // R12: a request is only raised while the tag store has room
   p_credit_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid |-> !tag_full);
   // R12: returned data always finds room
   p_rsp_room_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rd_rsp_valid |-> !rsp_full);
   // R10: every offered word has its last-flag waiting
   p_tag_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> !tag_empty);
   // R4: a full queue refuses entries
   p_full_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      q_full |-> !ent_ready);

endmodule

// File: tb/cmdlist_fetcher_bench.sv
`timescale 1ns/1ps
module cmdlist_fetcher_bench;
   localparam int CH_W = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ent_valid = 1'b0, ent_first = 1'b0, intr = 1'b0;
   logic [31:0]     ent_lo = '0, ent_hi = '0;
   logic [CH_W-1:0] ent_chan = '0;
   logic            rd_req_ready = 1'b0, rd_rsp_valid = 1'b0, word_ready = 1'b0;
   logic [31:0]     rd_rsp_data = '0;
   logic            ent_ready, stop_done, chan_chg, rd_req_valid;
   logic            word_valid, word_last, q_full, q_empty;
   logic [39:0]     rd_req_addr;
   logic [31:0]     word_data;

   cmdlist_fetcher #(.Q_DEPTH(4), .RB_DEPTH(8), .CH_W(CH_W)) u_cmdlist_fetcher (
      .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_ready(ent_ready),
      .ent_lo(ent_lo), .ent_hi(ent_hi), .ent_chan(ent_chan), .ent_first(ent_first),
      .intr(intr), .stop_done(stop_done), .chan_chg(chan_chg),
      .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
      .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
      .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
      .word_last(word_last), .q_full(q_full), .q_empty(q_empty)
   );

   always #10 clk = ~clk;

   int n_cmp = 0, n_bad = 0, cyc = 0;
   int rq_mode = 0, wr_mode = 0;
   logic [39:0] e_addr [1024];
   logic [31:0] e_data [1024];
   logic        e_last [1024];
   int          n_exp = 0, exp_chg = 0;
   logic [39:0] r_addr [1024];
   logic [31:0] r_data [1024];
   logic        r_last [1024];
   int          n_req = 0, n_word = 0, n_chg = 0, n_stop = 0, req_at_stop = 0;
   int          cmp_req = 0, cmp_word = 0;
   logic [39:0] pend [256];
   logic [7:0]  ph = '0, pt = '0;
   bit          had_chan = 0;
   logic [CH_W-1:0] last_chan = '0;

   function automatic logic [31:0] mdata(input logic [39:0] a);
      return a[31:0] ^ {a[39:32], 24'h0} ^ 32'h1357_9BDF;
   endfunction

   function automatic logic [31:0] mk_hi(input bit w, input int len, input logic [7:0] ahi);
      logic [20:0] l;
      l = 21'(len);
      return {w, l, 2'b00, ahi};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // memory model, consumer and monitors, all driven away from the clock edge
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         rd_req_ready = (rq_mode == 0) ? 1'b1 : (rq_mode == 1) ? (cyc % 3 != 0) : 1'b0;
         word_ready   = (wr_mode == 0) ? 1'b1 : (wr_mode == 1) ? (cyc % 4 != 1) : 1'b0;
         if (ph != pt) begin
            rd_rsp_valid = 1'b1;
            rd_rsp_data  = mdata(pend[ph]);
            ph++;
         end else begin
            rd_rsp_valid = 1'b0;
         end
         if (rst_n && rd_req_valid && rd_req_ready) begin
            pend[pt] = rd_req_addr;
            pt++;
            r_addr[n_req] = rd_req_addr;
            n_req++;
         end
         if (rst_n && word_valid && word_ready) begin
            r_data[n_word] = word_data;
            r_last[n_word] = word_last;
            n_word++;
         end
         if (rst_n && chan_chg) n_chg++;
         if (rst_n && stop_done) begin
            n_stop++;
            req_at_stop = n_req;
         end
      end
   end

   task automatic push(input logic [31:0] lo, input logic [31:0] hi, input logic [CH_W-1:0] ch, input bit first);
      logic [39:0] base;
      int len;
      base = {hi[7:0], lo[31:2], 2'b00};
      len  = int'(hi[30:10]);
      for (int k = 0; k < len; k++) begin
         e_addr[n_exp] = base + 40'(4 * k);
         e_data[n_exp] = mdata(base + 40'(4 * k));
         e_last[n_exp] = (k == len - 1);
         n_exp++;
      end
      if (!had_chan || ch != last_chan) exp_chg++;
      had_chan  = 1;
      last_chan = ch;
      @(negedge clk);
      ent_valid = 1'b1; ent_lo = lo; ent_hi = hi; ent_chan = ch; ent_first = first;
      while (!ent_ready) @(negedge clk);
      @(negedge clk);
      ent_valid = 1'b0;
   endtask

   task automatic drain_and_compare(input string tag);
      for (int t = 0; t < 3000 && (n_word < n_exp || n_req < n_exp); t++) @(negedge clk);
      repeat (6) @(negedge clk);
      chk(n_req == n_exp, {tag, " R2 request count"}, 64'(n_req), 64'(n_exp));
      chk(n_word == n_exp, {tag, " R10 word count"}, 64'(n_word), 64'(n_exp));
      for (int i = cmp_req; i < n_req && i < n_exp; i++)
         chk(r_addr[i] == e_addr[i], {tag, " R1 R2 address"}, 64'(r_addr[i]), 64'(e_addr[i]));
      for (int i = cmp_word; i < n_word && i < n_exp; i++) begin
         chk(r_data[i] == e_data[i], {tag, " R10 data"}, 64'(r_data[i]), 64'(e_data[i]));
         chk(r_last[i] == e_last[i], {tag, " R10 last flag"}, 64'(r_last[i]), 64'(e_last[i]));
      end
      cmp_req  = n_req;
      cmp_word = n_word;
      chk(n_chg == exp_chg, {tag, " R8 channel pulses"}, 64'(n_chg), 64'(exp_chg));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n_word, n_exp);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int base;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(ent_ready == 1'b1, "R11 ent_ready", 64'(ent_ready), 1);
      chk(q_empty == 1'b1, "R11 q_empty", 64'(q_empty), 1);
      chk(word_valid == 1'b0, "R11 word_valid", 64'(word_valid), 0);
      chk(rd_req_valid == 1'b0, "R11 rd_req_valid", 64'(rd_req_valid), 0);
      chk(chan_chg == 1'b0 && stop_done == 1'b0, "R11 pulses idle", 64'({chan_chg, stop_done}), 0);

      // R1 R2 R10 R8 sweep over lengths, ready patterns, channels and address carries
      for (int p = 0; p < 4; p++) begin
         rq_mode = p & 1;
         wr_mode = (p >> 1) & 1;
         for (int len = 1; len <= 6; len++) begin
            logic [31:0] lo;
            lo = (len % 2 == 0) ? (32'hFFFF_FFF0 | 32'(p)) : (32'h0001_2340 + 32'(len * 64) + 32'(p));
            push(lo, mk_hi(0, len, 8'(8'h10 + p * 7 + len)), CH_W'((len + p) % 3 / 2), (len == 1));
         end
         drain_and_compare("sweep");
      end
      rq_mode = 0; wr_mode = 0;

      // R3 zero-length entry alone, then between two others
      base = n_req;
      push(32'h0000_1000, mk_hi(0, 0, 8'h00), 3'd5, 1);
      repeat (10) @(negedge clk);
      chk(n_req == base, "R3 zero length issues no read", 64'(n_req), 64'(base));
      chk(n_word == n_exp, "R3 zero length issues no word", 64'(n_word), 64'(n_exp));
      push(32'h0000_2000, mk_hi(0, 2, 8'h01), 3'd5, 1);
      push(32'h0000_3000, mk_hi(0, 0, 8'h01), 3'd6, 0);
      push(32'h0000_4000, mk_hi(0, 3, 8'h01), 3'd6, 0);
      drain_and_compare("R3");

      // R7 prefetch runs ahead of a stalled consumer
      wr_mode = 2;
      base = n_req;
      push(32'h0000_5000, mk_hi(0, 3, 8'h02), 3'd1, 1);
      push(32'h0000_6000, mk_hi(0, 3, 8'h02), 3'd1, 0);
      repeat (20) @(negedge clk);
      chk(n_req - base == 6, "R7 both segments requested early", 64'(n_req - base), 6);
      wr_mode = 0;
      drain_and_compare("R7");

      // R5 a wait entry holds its reads until earlier words drain
      wr_mode = 2;
      base = n_req;
      push(32'h0000_7000, mk_hi(0, 3, 8'h03), 3'd1, 1);
      push(32'h0000_8000, mk_hi(1, 3, 8'h03), 3'd1, 0);
      repeat (20) @(negedge clk);
      chk(n_req - base == 3, "R5 wait entry deferred", 64'(n_req - base), 3);
      wr_mode = 0;
      drain_and_compare("R5");

      // R6 entries after a wait in the same batch are deferred
      wr_mode = 2;
      base = n_req;
      push(32'h0000_9000, mk_hi(1, 2, 8'h04), 3'd2, 1);
      push(32'h0000_A000, mk_hi(0, 2, 8'h04), 3'd2, 0);
      repeat (20) @(negedge clk);
      chk(n_req - base == 2, "R6 later batch entry deferred", 64'(n_req - base), 2);
      wr_mode = 0;
      drain_and_compare("R6 a");
      // R6 a new batch clears the wait history
      wr_mode = 2;
      base = n_req;
      push(32'h0000_B000, mk_hi(0, 2, 8'h05), 3'd2, 1);
      push(32'h0000_C000, mk_hi(0, 2, 8'h05), 3'd3, 1);
      repeat (20) @(negedge clk);
      chk(n_req - base == 4, "R6 new batch prefetches", 64'(n_req - base), 4);
      wr_mode = 0;
      drain_and_compare("R6 b");

      // R4 full queue refuses an entry
      rq_mode = 2;
      for (int i = 0; i < 5; i++)
         push(32'h0001_0000 + 32'(i * 16), mk_hi(0, 1, 8'h06), 3'd4, (i == 0));
      repeat (2) @(negedge clk);
      chk(q_full == 1'b1, "R4 q_full", 64'(q_full), 1);
      chk(ent_ready == 1'b0, "R4 ent_ready low when full", 64'(ent_ready), 0);
      ent_valid = 1'b1; ent_lo = 32'h0002_0000; ent_hi = mk_hi(0, 5, 8'h07);
      ent_chan = 3'd7; ent_first = 1'b0;
      repeat (3) @(negedge clk);
      ent_valid = 1'b0;
      rq_mode = 0;
      drain_and_compare("R4");
      chk(q_empty == 1'b1, "R4 refused entry not queued", 64'(q_empty), 1);

      // R9 stop request finishes the current segment, pauses, then resumes
      rq_mode = 2;
      base = n_stop;
      push(32'h0003_0000, mk_hi(0, 2, 8'h08), 3'd4, 1);
      push(32'h0003_1000, mk_hi(0, 2, 8'h08), 3'd4, 0);
      repeat (3) @(negedge clk);
      req_at_stop = -1;
      intr = 1'b1;
      @(negedge clk);
      intr = 1'b0;
      int_base_set: begin end
      rq_mode = 0;
      drain_and_compare("R9");
      chk(n_stop - base == 1, "R9 one stop pulse", 64'(n_stop - base), 1);
      chk(req_at_stop == n_req - 2, "R9 pause after first segment", 64'(req_at_stop), 64'(n_req - 2));

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule